// File: doc/BRIEF.md
# RTC Interrupt Aggregation Controller

This block gathers the timing events of a real-time clock and turns them into interrupts. Five sources reach it as one-cycle pulses: a power-fail event, a set of six periodic tick rates, an alarm match and two timer expiries. It latches them into a main status register, where each source has one bit, and into a periodic flag register, where each tick rate has one bit. Software can poll these registers even when every interrupt is disabled.

Each source has an enable. A per-source steering bit sends it to one of two interrupt pins: the primary pin or the secondary multi-function pin. Each pin has its own polarity and its own choice of push-pull or open-drain drive. The secondary pin takes part in interrupts only when the mode register configures it as an interrupt output.

Software reaches the registers over a byte-wide strobe bus with a 3-bit address and two select bits. Main status bits D2 to D5 are cleared by writing a one to them. The periodic flags clear when they are read. The power-fail bit stays set until a power-good input reports recovery.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, all registers read 0. Both pins are released (`intr_o`=0, `intr_oe`=0, `mfo_o`=0, `mfo_oe`=0).
- R2: Main status bit positions are D1 power fail, D3 alarm, D4 timer 0 and D5 timer 1. D3 to D5 set on their event whether or not they are enabled. D1 sets only while enable bit 1 of control register 1 is set. D2 sets only when a tick arrives whose rate bit is set in control register 0.
- R3: The periodic flag register (bits 0 to 5) sets on every tick, whatever control register 0 holds. A read at address 3 with both selects 0 returns the flags and clears them all. A tick in the same cycle as the read survives.
- R4: A write to address 0, with any select values, clears each of D2 to D5 whose data bit is 1. A data bit of 0 leaves its status bit unchanged. The write never clears D1.
- R5: D1, once set, holds until `pwr_ok_i` is high at a clock edge. A power-fail event in that same cycle keeps it set.
- R6: Status bit k drives a pin only while enable bit k of control register 1 is set. Routing bit k selects the pin: 0 for the primary pin, 1 for the secondary pin. The positions k are the same as in R2.
- R7: Mode register bits: bit 0 makes the primary pin active-high, bit 1 makes it push-pull, bit 2 makes the secondary pin active-high, bit 3 makes it push-pull, and bit 4 makes the secondary pin an interrupt output. In push-pull mode, oe=1 and the output carries the level. In open-drain mode, the output is 0 and oe=1 exactly when the level is low. With bit 4 clear, the secondary pin stays inactive.
- R8: Bit D0 of a main status read is 1 when the primary pin is active, or when the secondary pin is active while configured as an interrupt output. Otherwise it is 0.
- R9: Register map, with selects written (register-select, page). Address 3 at (0,0) is the periodic flags. Address 4 at (0,0) is routing. Address 2 at (1,0) is mode. Address 3 at (1,0) is control 0. Address 4 at (1,0) is control 1. Configuration registers read back what was written. With page 1, every address except 0 reads 0 and ignores writes.
- R10: If a W1C write and the setting event hit the same main status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pf_i | input | 1 | Power-fail event pulse |
| pwr_ok_i | input | 1 | Power restored indication |
| tick_i | input | 6 | Periodic tick pulses, one per rate |
| ev_alarm_i | input | 1 | Alarm match pulse |
| ev_tm0_i | input | 1 | Timer 0 expiry pulse |
| ev_tm1_i | input | 1 | Timer 1 expiry pulse |
| bus_rs | input | 1 | Register-select bit |
| bus_ps | input | 1 | Page-select bit |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| intr_o | output | 1 | Primary interrupt pin data |
| intr_oe | output | 1 | Primary interrupt pin drive enable |
| mfo_o | output | 1 | Secondary pin data |
| mfo_oe | output | 1 | Secondary pin drive enable |

## Verification
The assertions assume that events and bus strobes are single-cycle pulses sampled at the rising edge. They also assume that `bus_wr` and `bus_rd` are never both high in one cycle. The bench drives every input at the falling edge and holds it for exactly one cycle, so each pulse meets one rising edge. Set/clear collisions are created on purpose only in the directed cases for R3, R5 and R10. Elsewhere, clears and reads are issued while the related event inputs are low.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   // main status / enable / routing bit positions
   localparam int B_PF  = 1;
   localparam int B_PER = 2;
   localparam int B_ALM = 3;
   localparam int B_TM0 = 4;
   localparam int B_TM1 = 5;
   // mode register bit positions
   localparam int M_INT_AH  = 0;
   localparam int M_INT_PP  = 1;
   localparam int M_MFO_AH  = 2;
   localparam int M_MFO_PP  = 3;
   localparam int M_MFO_IRQ = 4;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_MAIN, SEL_PFLAG, SEL_ROUTE, SEL_CTL0, SEL_CTL1, SEL_MODE
   } reg_sel_e;

   function automatic reg_sel_e decode(input logic rs, input logic ps,
                                       input logic [2:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == 3'd0)
         s = SEL_MAIN;
      else if (!ps) begin
         case ({rs, a})
            4'b0_011: s = SEL_PFLAG;
            4'b0_100: s = SEL_ROUTE;
            4'b1_010: s = SEL_MODE;
            4'b1_011: s = SEL_CTL0;
            4'b1_100: s = SEL_CTL1;
            default:  s = SEL_NONE;
         endcase
      end
      return s;
   endfunction
endpackage

// File: rtl/rtc_irq_cfg.sv
module rtc_irq_cfg
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] route_q,
   output logic [DATA_W-1:0] ctl0_q,
   output logic [DATA_W-1:0] ctl1_q,
   output logic [DATA_W-1:0] mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         ctl0_q  <= '0;
         ctl1_q  <= '0;
         mode_q  <= '0;
      end else if (wr) begin
         case (sel)
            SEL_ROUTE: route_q <= wdata;
            SEL_CTL0:  ctl0_q  <= wdata;
            SEL_CTL1:  ctl1_q  <= wdata;
            SEL_MODE:  mode_q  <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_TICK = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_pf,
   input  logic              pwr_ok,
   input  logic [N_TICK-1:0] tick,
   input  logic              ev_alm,
   input  logic              ev_tm0,
   input  logic              ev_tm1,
   input  logic [DATA_W-1:0] ctl0,
   input  logic [DATA_W-1:0] ctl1,
   input  logic [DATA_W-1:0] w1c_mask,
   input  logic              pflag_rd,
   output logic [DATA_W-1:0] main_q,
   output logic [N_TICK-1:0] pflag_q
);
   logic [DATA_W-1:0] set_v, clr_v;

   always_comb begin
      set_v        = '0;
      set_v[B_PF]  = ev_pf & ctl1[B_PF];
      set_v[B_PER] = |(tick & ctl0[N_TICK-1:0]);
      set_v[B_ALM] = ev_alm;
      set_v[B_TM0] = ev_tm0;
      set_v[B_TM1] = ev_tm1;
      clr_v              = '0;
      clr_v[B_PF]        = pwr_ok;
      clr_v[B_TM1:B_PER] = w1c_mask[B_TM1:B_PER];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q  <= '0;
         pflag_q <= '0;
      end else begin
         main_q  <= (main_q & ~clr_v) | set_v;
         pflag_q <= (pflag_q & ~{N_TICK{pflag_rd}}) | tick;
      end
   end
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin (
   input  logic act,
   input  logic act_high,
   input  logic push_pull,
   output logic pin_o,
   output logic pin_oe
);
   logic level;
   assign level  = ~(act ^ act_high);
   assign pin_o  = push_pull ? level : 1'b0;
   assign pin_oe = push_pull ? 1'b1 : ~level;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int N_TICK = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_pf_i,
   input  logic              pwr_ok_i,
   input  logic [N_TICK-1:0] tick_i,
   input  logic              ev_alarm_i,
   input  logic              ev_tm0_i,
   input  logic              ev_tm1_i,
   input  logic              bus_rs,
   input  logic              bus_ps,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              intr_o,
   output logic              intr_oe,
   output logic              mfo_o,
   output logic              mfo_oe
);
   localparam int N_PIN = 2;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W must be at least 3");
      end
      if (N_TICK > DATA_W || N_TICK < 1) begin : g_bad_nt
         $error("N_TICK must be 1..DATA_W");
      end
   endgenerate

   reg_sel_e          sel;
   logic              hi_zero;
   logic [DATA_W-1:0] route_q, ctl0_q, ctl1_q, mode_q, main_q, w1c_mask;
   logic [N_TICK-1:0] pflag_q;
   logic [DATA_W-1:0] pend;
   logic              intr_act, mfo_act, irq_flag;
   logic [N_PIN-1:0]  p_act, p_ah, p_pp, p_o, p_oe;

   assign hi_zero  = (bus_addr >> 3) == '0;
   assign sel      = hi_zero ? decode(bus_rs, bus_ps, bus_addr[2:0]) : SEL_NONE;
   assign w1c_mask = (bus_wr && sel == SEL_MAIN) ? bus_wdata : '0;

   rtc_irq_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
      .route_q(route_q), .ctl0_q(ctl0_q), .ctl1_q(ctl1_q), .mode_q(mode_q)
   );

   rtc_irq_status #(.DATA_W(DATA_W), .N_TICK(N_TICK)) u_stat (
      .clk(clk), .rst_n(rst_n), .ev_pf(ev_pf_i), .pwr_ok(pwr_ok_i),
      .tick(tick_i), .ev_alm(ev_alarm_i), .ev_tm0(ev_tm0_i), .ev_tm1(ev_tm1_i),
      .ctl0(ctl0_q), .ctl1(ctl1_q), .w1c_mask(w1c_mask),
      .pflag_rd(bus_rd && sel == SEL_PFLAG),
      .main_q(main_q), .pflag_q(pflag_q)
   );

   assign pend     = main_q & ctl1_q;
   assign intr_act = |(pend[B_TM1:B_PF] & ~route_q[B_TM1:B_PF]);
   assign mfo_act  = mode_q[M_MFO_IRQ] & (|(pend[B_TM1:B_PF] & route_q[B_TM1:B_PF]));
   assign irq_flag = intr_act | mfo_act;

   assign p_act = {mfo_act, intr_act};
   assign p_ah  = {mode_q[M_MFO_AH], mode_q[M_INT_AH]};
   assign p_pp  = {mode_q[M_MFO_PP], mode_q[M_INT_PP]};

   generate
      for (genvar i = 0; i < N_PIN; i++) begin : g_pin
         rtc_irq_pin u_pin (
            .act(p_act[i]), .act_high(p_ah[i]), .push_pull(p_pp[i]),
            .pin_o(p_o[i]), .pin_oe(p_oe[i])
         );
      end
   endgenerate

   assign intr_o  = p_o[0];
   assign intr_oe = p_oe[0];
   assign mfo_o   = p_o[1];
   assign mfo_oe  = p_oe[1];

   always_comb begin
      case (sel)
         SEL_MAIN:  bus_rdata = {main_q[DATA_W-1:1], irq_flag};
         SEL_PFLAG: bus_rdata = DATA_W'(pflag_q);
         SEL_ROUTE: bus_rdata = route_q;
         SEL_CTL0:  bus_rdata = ctl0_q;
         SEL_CTL1:  bus_rdata = ctl1_q;
         SEL_MODE:  bus_rdata = mode_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int N_TICK = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_alarm_i,
   input logic              pwr_ok_i,
   input logic [N_TICK-1:0] tick_i,
   input logic              bus_rs,
   input logic              bus_ps,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] main_q,
   input logic [N_TICK-1:0] pflag_q,
   input logic [DATA_W-1:0] ctl1_q,
   input logic [DATA_W-1:0] mode_q,
   input logic              intr_o,
   input logic              mfo_o,
   input logic              mfo_oe
);
   logic wr_main, rd_pflag;
   assign wr_main  = bus_wr && bus_addr == '0;
   assign rd_pflag = bus_rd && !bus_rs && !bus_ps && bus_addr == ADDR_W'(3);

   assert_alarm_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_alarm_i |=> main_q[3]);
   assert_pflag_cor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pflag && tick_i == '0) |=> pflag_q == '0);
   assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_main && bus_wdata[3] && !ev_alarm_i) |=> !main_q[3]);
   assert_w1c_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_main && !bus_wdata[4] && main_q[4]) |=> main_q[4]);
   assert_pf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (main_q[1] && !pwr_ok_i) |=> main_q[1]);
   assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl1_q[5:1] == '0 && mode_q[1]) |-> intr_o == !mode_q[0]);
   assert_od_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[1] |-> !intr_o);
   assert_mfo_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[4] && mode_q[3]) |-> (mfo_oe && mfo_o == !mode_q[2]));
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_main && bus_wdata[3] && ev_alarm_i) |=> main_q[3]);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_TICK(N_TICK)) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_alarm_i(ev_alarm_i), .pwr_ok_i(pwr_ok_i),
   .tick_i(tick_i), .bus_rs(bus_rs), .bus_ps(bus_ps), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
   .main_q(main_q), .pflag_q(pflag_q), .ctl1_q(ctl1_q), .mode_q(mode_q),
   .intr_o(intr_o), .mfo_o(mfo_o), .mfo_oe(mfo_oe)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
   logic clk = 0, rst_n = 0;
   logic ev_pf = 0, pwr_ok = 0, ev_alm = 0, ev_t0 = 0, ev_t1 = 0;
   logic [5:0] tick = '0;
   logic rs = 0, ps = 0, wr = 0, rd = 0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic intr_o, intr_oe, mfo_o, mfo_oe;
   int n_run = 0, n_fail = 0;
   logic done = 0;

   always #10 clk = ~clk;

   rtc_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ev_pf_i(ev_pf), .pwr_ok_i(pwr_ok), .tick_i(tick),
      .ev_alarm_i(ev_alm), .ev_tm0_i(ev_t0), .ev_tm1_i(ev_t1),
      .bus_rs(rs), .bus_ps(ps), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata),
      .intr_o(intr_o), .intr_oe(intr_oe), .mfo_o(mfo_o), .mfo_oe(mfo_oe)
   );

   typedef struct packed {
      logic [7:0] route, ctl1, mode;
      logic [2:0] ev;      // {t1, t0, alarm} = status bits 5..3
      logic [4:0] exp;     // {intr_o, intr_oe, mfo_o, mfo_oe, D0}
   } vec_t;
   localparam vec_t VECS [7] = '{
      '{8'h00, 8'h08, 8'h03, 3'b001, 5'b11001},
      '{8'h00, 8'h00, 8'h03, 3'b001, 5'b01000},
      '{8'h08, 8'h08, 8'h1C, 3'b001, 5'b00111},
      '{8'h08, 8'h08, 8'h0C, 3'b001, 5'b00010},
      '{8'h10, 8'h30, 8'h10, 3'b100, 5'b01001},
      '{8'h10, 8'h30, 8'h10, 3'b010, 5'b00011},
      '{8'h30, 8'h30, 8'h05, 3'b110, 5'b01010}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic r, input logic p, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); rs = r; ps = p; addr = a; wdata = d; wr = 1;
      @(negedge clk); wr = 0;
   endtask

   task automatic brd(input logic r, input logic p, input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); rs = r; ps = p; addr = a; rd = 1;
      #1 d = rdata;
      @(negedge clk); rd = 0;
   endtask

   task automatic events(input logic [2:0] ev);
      @(negedge clk); {ev_t1, ev_t0, ev_alm} = ev;
      @(negedge clk); {ev_t1, ev_t0, ev_alm} = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pins", {intr_o, intr_oe, mfo_o, mfo_oe}, 4'b0000);
      brd(0, 0, 3'd0, d); check("R1 main", d, 0);
      rst_n = 1;
      brd(1, 0, 3'd4, d); check("R1 ctl1", d, 0);
      brd(0, 0, 3'd3, d); check("R1 pflag", d, 0);

      // vector table: R6 R7 R8 and R2
      foreach (VECS[i]) begin
         bwr(0, 0, 3'd4, VECS[i].route);
         bwr(1, 0, 3'd4, VECS[i].ctl1);
         bwr(1, 0, 3'd2, VECS[i].mode);
         events(VECS[i].ev);
         check("R6/R7 pins", {intr_o, intr_oe, mfo_o, mfo_oe}, VECS[i].exp[4:1]);
         brd(0, 0, 3'd0, d);
         check("R8 D0", d[0], VECS[i].exp[0]);
         check("R2 status", d[5:3], VECS[i].ev);
         bwr(0, 0, 3'd0, 8'h38);
      end

      // R9 map and page select
      bwr(1, 0, 3'd3, 8'h2A);
      brd(1, 0, 3'd3, d); check("R9 ctl0 readback", d, 8'h2A);
      bwr(0, 1, 3'd4, 8'hFF);
      brd(0, 0, 3'd4, d); check("R9 page1 write ignored", d, 8'h30);
      brd(1, 1, 3'd3, d); check("R9 page1 read zero", d, 0);
      brd(0, 1, 3'd0, d); check("R9 main on page1", d[5:1], 0);

      // R3 periodic flags, R2 periodic mask
      bwr(1, 0, 3'd3, 8'h00);
      @(negedge clk); tick = 6'h05; @(negedge clk); tick = 0;
      brd(1, 1, 3'd0, d); check("R2 periodic masked", d[2], 0);
      brd(0, 0, 3'd3, d); check("R3 flags read", d, 8'h05);
      brd(0, 0, 3'd3, d); check("R3 cleared on read", d, 0);
      @(negedge clk); rs = 0; ps = 0; addr = 3'd3; rd = 1; tick = 6'h02;
      #1 check("R3 read during tick", rdata, 0);
      @(negedge clk); rd = 0; tick = 0;
      brd(0, 0, 3'd3, d); check("R3 tick survives read", d, 8'h02);
      bwr(1, 0, 3'd3, 8'h01);
      @(negedge clk); tick = 6'h01; @(negedge clk); tick = 0;
      brd(0, 0, 3'd0, d); check("R2 periodic enabled", d[2], 1);

      // R4 W1C
      bwr(1, 0, 3'd4, 8'h00);
      events(3'b001);
      bwr(0, 0, 3'd0, 8'h00);
      brd(0, 0, 3'd0, d); check("R4 zero write", d[5:2], 4'b0011);
      bwr(1, 1, 3'd0, 8'h08);
      brd(0, 0, 3'd0, d); check("R4 one clears", d[5:2], 4'b0001);
      bwr(0, 0, 3'd0, 8'h04);

      // R10 collision
      events(3'b001);
      @(negedge clk); addr = 3'd0; wdata = 8'h08; wr = 1; ev_alm = 1;
      @(negedge clk); wr = 0; ev_alm = 0;
      brd(0, 0, 3'd0, d); check("R10 set wins", d[3], 1);
      bwr(0, 0, 3'd0, 8'h08);

      // R5 power fail
      @(negedge clk); ev_pf = 1; @(negedge clk); ev_pf = 0;
      brd(0, 0, 3'd0, d); check("R2 pf disabled", d[1], 0);
      bwr(1, 0, 3'd4, 8'h02);
      @(negedge clk); ev_pf = 1; @(negedge clk); ev_pf = 0;
      bwr(0, 0, 3'd0, 8'hFE);
      repeat (5) @(negedge clk);
      brd(0, 0, 3'd0, d); check("R5 sticky", d[1:0], 2'b11);
      @(negedge clk); pwr_ok = 1; @(negedge clk); pwr_ok = 0;
      brd(0, 0, 3'd0, d); check("R5 restored", d[1:0], 2'b00);
      @(negedge clk); pwr_ok = 1; ev_pf = 1; @(negedge clk); pwr_ok = 0; ev_pf = 0;
      brd(0, 0, 3'd0, d); check("R5 event wins", d[1], 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule